// File: doc/BRIEF.md
# Scaler Request Validator and Allocator

This block arbitrates a small pool of scalers among several users on one display pipe: a number of planes plus one pipe-level user. Each request names a user and gives the source and destination sizes together with a set of flags. The block decides whether that user may hold a scaler, releases a scaler the user no longer needs, and binds a free one when a new claim is accepted. It keeps a mask of the users that hold a scaler, a busy bit for each scaler, and the scaler number held by each user. Programming the scaler hardware and the pixel datapath are handled by other blocks.

A request is a one-cycle strobe. The verdict and the updated bookkeeping appear on the next cycle. A user needs a scaler when its need flag is set or when the source and destination sizes differ. A user that does not need one, or that is forced off, gives its scaler back, and this always counts as success. A release only changes the bookkeeping here. Freeing the hardware itself is left to the logic that programs it.

Top module: `scl_grant_unit`

## Requirements
- R1: A scaler is required when the source width differs from the destination width or the source height differs from the destination height, even with `need_scaler` low.
- R2: A request that requires a scaler while `disp_enabled` and `interlaced` are both high is rejected and changes no state. With `disp_enabled` low, the interlaced flag has no effect.
- R3: When `force_detach` is high or no scaler is required, and R2 does not reject the request, the request is accepted. If the user holds a scaler, its mask bit and that scaler's busy bit are cleared. The response id is -1 (3'b111).
- R4: When `fmt_420sp` is high, a claim whose source width or height is below 16 is rejected.
- R5: A claim with any source or destination dimension below 8 is rejected. A dimension of exactly 8 is allowed.
- R6: With `ext_limits` low, every dimension must be at most 4096. With it high, widths may reach 5120 and heights must stay at most 4096. A claim outside these limits is rejected.
- R7: An accepted claim sets the user's bit (bit number = user index) in `user_mask` and returns the held scaler number on `rsp_sid`.
- R8: A user without a scaler is bound to the lowest-numbered scaler whose busy bit is clear. If none is free, the claim is rejected, the mask is unchanged and `rsp_sid` is -1.
- R9: `rsp_valid` is high exactly in the cycle after each `req_valid` cycle. Without a request, the mask and the busy bits hold.
- R10: Reset clears `user_mask`, `scaler_busy` and `rsp_valid`, and leaves every user unassigned.
- R11: A claim from a user that already holds a scaler keeps that same scaler and takes no second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_user | input | 3 | Requesting user index |
| src_w | input | 13 | Source width |
| src_h | input | 13 | Source height |
| dst_w | input | 13 | Destination width |
| dst_h | input | 13 | Destination height |
| force_detach | input | 1 | Release the user's scaler unconditionally |
| need_scaler | input | 1 | User asks for a scaler even at equal sizes |
| disp_enabled | input | 1 | Display pipe enabled |
| interlaced | input | 1 | Pipe runs an interlaced timing |
| fmt_420sp | input | 1 | Source is 4:2:0 semi-planar |
| ext_limits | input | 1 | Use the extended size limits |
| rsp_valid | output | 1 | Response valid |
| rsp_accept | output | 1 | Request accepted |
| rsp_sid | output | 3 | Scaler held by the user after the request, two's complement, -1 = none |
| user_mask | output | 8 | One bit per user holding a scaler |
| scaler_busy | output | 2 | One bit per scaler in use |

## Verification
The hardest case to reach is the rejection because no scaler is free. It needs every scaler to be held by a different user at the moment a third user claims. The table therefore builds up ownership step by step, releasing and re-claiming so that the freed scaler is not always the highest one. A reset in the middle of the run, while two users hold scalers, is followed by a claim from a user whose stale id would otherwise point at scaler 1. This shows that the per-user ids return to unassigned.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    VD_RELEASE = 2'd0,
    VD_REJECT  = 2'd1,
    VD_CLAIM   = 2'd2
  } verdict_e;

endpackage

// File: rtl/scl_screen.sv
module scl_screen
  import scl_pkg::*;
#(
  parameter int DIM_W     = 13,
  parameter int MIN_DIM   = 8,
  parameter int MIN_SUBS  = 16,
  parameter int MAX_STD   = 4096,
  parameter int MAX_EXT_W = 5120,
  parameter int MAX_EXT_H = 4096
) (
  input  logic [DIM_W-1:0] src_w,
  input  logic [DIM_W-1:0] src_h,
  input  logic [DIM_W-1:0] dst_w,
  input  logic [DIM_W-1:0] dst_h,
  input  logic             force_detach,
  input  logic             need_scaler,
  input  logic             disp_enabled,
  input  logic             interlaced,
  input  logic             fmt_420sp,
  input  logic             ext_limits,
  output verdict_e         verdict
);

  localparam logic [DIM_W-1:0] LIM_MIN   = DIM_W'(MIN_DIM);
  localparam logic [DIM_W-1:0] LIM_SUBS  = DIM_W'(MIN_SUBS);
  localparam logic [DIM_W-1:0] LIM_STD   = DIM_W'(MAX_STD);
  localparam logic [DIM_W-1:0] LIM_EXT_W = DIM_W'(MAX_EXT_W);
  localparam logic [DIM_W-1:0] LIM_EXT_H = DIM_W'(MAX_EXT_H);

  logic             size_diff;
  logic             required;
  logic             too_small;
  logic             too_large;
  logic             subs_short;
  logic [DIM_W-1:0] cap_w;
  logic [DIM_W-1:0] cap_h;

  always_comb begin
    size_diff  = (src_w != dst_w) || (src_h != dst_h);
    required   = need_scaler || size_diff;
    cap_w      = ext_limits ? LIM_EXT_W : LIM_STD;
    cap_h      = ext_limits ? LIM_EXT_H : LIM_STD;
    too_small  = (src_w < LIM_MIN) || (src_h < LIM_MIN) ||
                 (dst_w < LIM_MIN) || (dst_h < LIM_MIN);
    too_large  = (src_w > cap_w) || (dst_w > cap_w) ||
                 (src_h > cap_h) || (dst_h > cap_h);
    subs_short = fmt_420sp && ((src_w < LIM_SUBS) || (src_h < LIM_SUBS));

    if (required && disp_enabled && interlaced) begin
      verdict = VD_REJECT;
    end else if (force_detach || !required) begin
      verdict = VD_RELEASE;
    end else if (subs_short || too_small || too_large) begin
      verdict = VD_REJECT;
    end else begin
      verdict = VD_CLAIM;
    end
  end

endmodule

// File: rtl/scl_pick_free.sv
module scl_pick_free #(
  parameter int N_SCALERS = 2,
  parameter int IDX_W     = 1
) (
  input  logic [N_SCALERS-1:0] busy,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_SCALERS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/scl_id_table.sv
module scl_id_table #(
  parameter int N_USERS = 8,
  parameter int UIDX_W  = 3,
  parameter int SID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [UIDX_W-1:0] wr_user,
  input  logic [SID_W-1:0]  wr_sid,
  input  logic [UIDX_W-1:0] rd_user,
  output logic [SID_W-1:0]  rd_sid
);

  logic [SID_W-1:0] slot_q [N_USERS];

  for (genvar u = 0; u < N_USERS; u++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_user == UIDX_W'(u));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[u] <= '1;
      end else if (slot_we) begin
        slot_q[u] <= wr_sid;
      end
    end
  end

  assign rd_sid = slot_q[rd_user];

endmodule

// File: rtl/scl_grant_unit.sv
module scl_grant_unit
  import scl_pkg::*;
#(
  parameter int N_USERS   = 8,
  parameter int N_SCALERS = 2,
  parameter int DIM_W     = 13,
  parameter int MIN_DIM   = 8,
  parameter int MIN_SUBS  = 16,
  parameter int MAX_STD   = 4096,
  parameter int MAX_EXT_W = 5120,
  parameter int MAX_EXT_H = 4096,
  localparam int UIDX_W   = $clog2(N_USERS),
  localparam int IDX_W    = (N_SCALERS > 1) ? $clog2(N_SCALERS) : 1,
  localparam int SID_W    = $clog2(N_SCALERS + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [UIDX_W-1:0]    req_user,
  input  logic [DIM_W-1:0]     src_w,
  input  logic [DIM_W-1:0]     src_h,
  input  logic [DIM_W-1:0]     dst_w,
  input  logic [DIM_W-1:0]     dst_h,
  input  logic                 force_detach,
  input  logic                 need_scaler,
  input  logic                 disp_enabled,
  input  logic                 interlaced,
  input  logic                 fmt_420sp,
  input  logic                 ext_limits,
  output logic                 rsp_valid,
  output logic                 rsp_accept,
  output logic [SID_W-1:0]     rsp_sid,
  output logic [N_USERS-1:0]   user_mask,
  output logic [N_SCALERS-1:0] scaler_busy
);

  localparam logic [SID_W-1:0] SID_NONE = '1;

  verdict_e              verdict;
  logic                  free_found;
  logic [IDX_W-1:0]      free_idx;
  logic [SID_W-1:0]      cur_sid;
  logic                  cur_has;

  logic [N_USERS-1:0]    mask_q, mask_d;
  logic [N_SCALERS-1:0]  busy_q, busy_d;
  logic                  rv_q;
  logic                  acc_q, acc_d;
  logic [SID_W-1:0]      sid_q, sid_d;
  logic                  id_we;
  logic [SID_W-1:0]      id_wdata;

  scl_screen #(
    .DIM_W     (DIM_W),
    .MIN_DIM   (MIN_DIM),
    .MIN_SUBS  (MIN_SUBS),
    .MAX_STD   (MAX_STD),
    .MAX_EXT_W (MAX_EXT_W),
    .MAX_EXT_H (MAX_EXT_H)
  ) u_screen (
    .src_w        (src_w),
    .src_h        (src_h),
    .dst_w        (dst_w),
    .dst_h        (dst_h),
    .force_detach (force_detach),
    .need_scaler  (need_scaler),
    .disp_enabled (disp_enabled),
    .interlaced   (interlaced),
    .fmt_420sp    (fmt_420sp),
    .ext_limits   (ext_limits),
    .verdict      (verdict)
  );

  scl_pick_free #(
    .N_SCALERS (N_SCALERS),
    .IDX_W     (IDX_W)
  ) u_pick (
    .busy  (busy_q),
    .found (free_found),
    .idx   (free_idx)
  );

  scl_id_table #(
    .N_USERS (N_USERS),
    .UIDX_W  (UIDX_W),
    .SID_W   (SID_W)
  ) u_ids (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (id_we),
    .wr_user (req_user),
    .wr_sid  (id_wdata),
    .rd_user (req_user),
    .rd_sid  (cur_sid)
  );

  // A user holds a scaler when its stored id is non-negative
  assign cur_has = ($signed(cur_sid) >= 0);

  // Next-state decision
  always_comb begin
    mask_d   = mask_q;
    busy_d   = busy_q;
    acc_d    = 1'b0;
    sid_d    = cur_sid;
    id_we    = 1'b0;
    id_wdata = SID_NONE;

    unique case (verdict)
      VD_RELEASE: begin
        acc_d = 1'b1;
        sid_d = SID_NONE;
        if (cur_has) begin
          mask_d[req_user]                = 1'b0;
          busy_d[cur_sid[IDX_W-1:0]]      = 1'b0;
          id_we                           = req_valid;
          id_wdata                        = SID_NONE;
        end
      end
      VD_CLAIM: begin
        if (cur_has) begin
          acc_d            = 1'b1;
          mask_d[req_user] = 1'b1;
        end else if (free_found) begin
          acc_d            = 1'b1;
          mask_d[req_user] = 1'b1;
          busy_d[free_idx] = 1'b1;
          sid_d            = SID_W'(free_idx);
          id_we            = req_valid;
          id_wdata         = SID_W'(free_idx);
        end else begin
          sid_d = SID_NONE;
        end
      end
      default: begin
        acc_d = 1'b0;
      end
    endcase
  end

  // State registers with the request strobe as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      busy_q <= '0;
      acc_q  <= 1'b0;
      sid_q  <= SID_NONE;
    end else if (req_valid) begin
      mask_q <= mask_d;
      busy_q <= busy_d;
      acc_q  <= acc_d;
      sid_q  <= sid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
    end else begin
      rv_q <= req_valid;
    end
  end

  assign rsp_valid   = rv_q;
  assign rsp_accept  = acc_q;
  assign rsp_sid     = sid_q;
  assign user_mask   = mask_q;
  assign scaler_busy = busy_q;

endmodule

// File: rtl/scl_grant_checker.sv
module scl_grant_checker #(
  parameter int N_USERS   = 8,
  parameter int N_SCALERS = 2,
  parameter int UIDX_W    = 3,
  parameter int IDX_W     = 1,
  parameter int SID_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [UIDX_W-1:0]    req_user,
  input logic                 rsp_valid,
  input logic                 rsp_accept,
  input logic [SID_W-1:0]     rsp_sid,
  input logic [N_USERS-1:0]   user_mask,
  input logic [N_SCALERS-1:0] scaler_busy
);

  // R9: response follows every request by one cycle
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9: no response without a request
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R9: bookkeeping holds while idle
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(user_mask) && $stable(scaler_busy)));

  // R2, R8: a rejection leaves the mask unchanged
  p_reject_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_accept) |-> (user_mask == $past(user_mask)));

  // R7: held scalers and holding users are counted alike
  p_count_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(user_mask) == $countones(scaler_busy));

  // R3: an accepted release leaves the user out of the mask
  p_release_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_accept && rsp_sid[SID_W-1]) |-> !user_mask[$past(req_user)]);

  // R8: an accepted grant marks its scaler busy and its user present
  p_grant_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_accept && !rsp_sid[SID_W-1]) |->
      (scaler_busy[rsp_sid[IDX_W-1:0]] && user_mask[$past(req_user)]));

endmodule

bind scl_grant_unit scl_grant_checker #(
  .N_USERS   (N_USERS),
  .N_SCALERS (N_SCALERS),
  .UIDX_W    (UIDX_W),
  .IDX_W     (IDX_W),
  .SID_W     (SID_W)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_user    (req_user),
  .rsp_valid   (rsp_valid),
  .rsp_accept  (rsp_accept),
  .rsp_sid     (rsp_sid),
  .user_mask   (user_mask),
  .scaler_busy (scaler_busy)
);

// File: tb/scl_grant_unit_bench.sv
module scl_grant_unit_bench;

  typedef struct packed {
    logic [2:0]  user;
    logic [12:0] sw;
    logic [12:0] sh;
    logic [12:0] dw;
    logic [12:0] dh;
    logic        en;
    logic        fd;
    logic        need;
    logic        intl;
    logic        f420;
    logic        ext;
    logic        acc;
    logic [2:0]  sid;
    logic [7:0]  mask;
    logic [1:0]  busy;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    // R3: equal sizes, no need, nothing held -> release success
    '{3'd0, 13'd1920, 13'd1080, 13'd1920, 13'd1080, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'b111, 8'h00, 2'b00},
    // R1: size mismatch forces a claim
    '{3'd0, 13'd1920, 13'd1080, 13'd3840, 13'd2160, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'd0,   8'h01, 2'b01},
    // R7: need flag at equal sizes
    '{3'd1, 13'd800,  13'd600,  13'd800,  13'd600,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1, 3'd1,   8'h03, 2'b11},
    // R8: pool exhausted
    '{3'd2, 13'd100,  13'd100,  13'd200,  13'd200,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'b111, 8'h03, 2'b11},
    // R11: holder keeps its scaler
    '{3'd0, 13'd1920, 13'd1080, 13'd1280, 13'd720,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'd0,   8'h03, 2'b11},
    // R3: forced detach
    '{3'd0, 13'd1920, 13'd1080, 13'd1280, 13'd720,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'b111, 8'h02, 2'b10},
    // R8: lowest free is scaler 0
    '{3'd2, 13'd100,  13'd100,  13'd200,  13'd200,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'd0,   8'h06, 2'b11},
    // R2: interlaced on enabled display, scaler required
    '{3'd1, 13'd800,  13'd600,  13'd800,  13'd600,  1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0, 3'd1,   8'h06, 2'b11},
    // R2/R3: interlaced but not required -> release
    '{3'd1, 13'd800,  13'd600,  13'd800,  13'd600,  1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1, 3'b111, 8'h04, 2'b01},
    // R4: 4:2:0 source width 15
    '{3'd3, 13'd15,   13'd64,   13'd30,   13'd128,  1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0, 3'b111, 8'h04, 2'b01},
    // R4: 4:2:0 source 16x16 allowed
    '{3'd3, 13'd16,   13'd16,   13'd32,   13'd32,   1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1, 3'd1,   8'h0C, 2'b11},
    // R3: not required -> release
    '{3'd3, 13'd16,   13'd16,   13'd16,   13'd16,   1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1, 3'b111, 8'h04, 2'b01},
    // R5: source width 7
    '{3'd4, 13'd7,    13'd64,   13'd64,   13'd64,   1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'b111, 8'h04, 2'b01},
    // R5: destination height 7
    '{3'd4, 13'd64,   13'd64,   13'd64,   13'd7,    1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'b111, 8'h04, 2'b01},
    // R6: width 4097 standard limits
    '{3'd4, 13'd64,   13'd64,   13'd4097, 13'd64,   1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'b111, 8'h04, 2'b01},
    // R6: width 4097 extended limits
    '{3'd4, 13'd64,   13'd64,   13'd4097, 13'd64,   1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1, 3'd1,   8'h14, 2'b11},
    // R6: height 4097 extended limits
    '{3'd5, 13'd64,   13'd64,   13'd64,   13'd4097, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0, 3'b111, 8'h14, 2'b11},
    // R3: forced detach of user 4
    '{3'd4, 13'd64,   13'd64,   13'd4097, 13'd64,   1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1, 3'b111, 8'h04, 2'b01},
    // R6: width 5121 extended limits
    '{3'd5, 13'd5120, 13'd64,   13'd5121, 13'd64,   1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0, 3'b111, 8'h04, 2'b01},
    // R6: width 5120 height 4096 extended
    '{3'd5, 13'd5120, 13'd4096, 13'd4096, 13'd4096, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1, 3'd1,   8'h24, 2'b11},
    // R6: same with standard limits, holder rejected but keeps id
    '{3'd5, 13'd5120, 13'd4096, 13'd4096, 13'd4096, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd1,   8'h24, 2'b11},
    // R3: forced detach of user 2
    '{3'd2, 13'd100,  13'd100,  13'd200,  13'd200,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 3'b111, 8'h20, 2'b10},
    // R2: interlaced with display disabled is allowed
    '{3'd6, 13'd64,   13'd64,   13'd128,  13'd128,  1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1, 3'd0,   8'h60, 2'b11},
    // R8: pool exhausted for user 7
    '{3'd7, 13'd8,    13'd8,    13'd8,    13'd8,    1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0, 3'b111, 8'h60, 2'b11},
    // R3: forced detach of user 6
    '{3'd6, 13'd64,   13'd64,   13'd128,  13'd128,  1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1, 3'b111, 8'h20, 2'b10},
    // R5: exact minimum 8x8 allowed
    '{3'd7, 13'd8,    13'd8,    13'd8,    13'd8,    1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1, 3'd0,   8'hA0, 2'b11}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_user;
  logic [12:0] src_w, src_h, dst_w, dst_h;
  logic        force_detach, need_scaler, disp_enabled, interlaced, fmt_420sp, ext_limits;
  logic        rsp_valid, rsp_accept;
  logic [2:0]  rsp_sid;
  logic [7:0]  user_mask;
  logic [1:0]  scaler_busy;

  int n_tests;
  int n_fail;
  bit done;

  scl_grant_unit u_scl_grant_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_user     (req_user),
    .src_w        (src_w),
    .src_h        (src_h),
    .dst_w        (dst_w),
    .dst_h        (dst_h),
    .force_detach (force_detach),
    .need_scaler  (need_scaler),
    .disp_enabled (disp_enabled),
    .interlaced   (interlaced),
    .fmt_420sp    (fmt_420sp),
    .ext_limits   (ext_limits),
    .rsp_valid    (rsp_valid),
    .rsp_accept   (rsp_accept),
    .rsp_sid      (rsp_sid),
    .user_mask    (user_mask),
    .scaler_busy  (scaler_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    req_user     = v.user;
    src_w        = v.sw;
    src_h        = v.sh;
    dst_w        = v.dw;
    dst_h        = v.dh;
    disp_enabled = v.en;
    force_detach = v.fd;
    need_scaler  = v.need;
    interlaced   = v.intl;
    fmt_420sp    = v.f420;
    ext_limits   = v.ext;
    req_valid    = 1'b1;
    @(negedge clk);
    req_valid    = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    req_valid = 1'b0;
    req_user = '0;
    src_w = 13'd64; src_h = 13'd64; dst_w = 13'd64; dst_h = 13'd64;
    force_detach = 1'b0; need_scaler = 1'b0; disp_enabled = 1'b1;
    interlaced = 1'b0; fmt_420sp = 1'b0; ext_limits = 1'b0;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R10 user_mask after reset", 32'(user_mask), 32'd0);
    chk("R10 scaler_busy after reset", 32'(scaler_busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      chk($sformatf("row %0d rsp_valid R9", i), 32'(rsp_valid), 32'd1);
      chk($sformatf("row %0d accept", i), 32'(rsp_accept), 32'(VECS[i].acc));
      chk($sformatf("row %0d sid", i), 32'(rsp_sid), 32'(VECS[i].sid));
      chk($sformatf("row %0d mask", i), 32'(user_mask), 32'(VECS[i].mask));
      chk($sformatf("row %0d busy", i), 32'(scaler_busy), 32'(VECS[i].busy));
    end

    // R9: response is a single pulse and idle cycles hold state
    @(negedge clk);
    chk("R9 rsp_valid drops", 32'(rsp_valid), 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 mask holds idle", 32'(user_mask), 32'hA0);
    chk("R9 busy holds idle", 32'(scaler_busy), 32'd3);

    // R10: reset in the middle while users 5 and 7 hold scalers
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mask cleared", 32'(user_mask), 32'd0);
    chk("R10 busy cleared", 32'(scaler_busy), 32'd0);
    chk("R10 rsp_valid cleared", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    apply('{3'd5, 13'd64, 13'd64, 13'd128, 13'd128, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,
            1'b1, 3'd0, 8'h20, 2'b01});
    chk("R10 stale id cleared sid", 32'(rsp_sid), 32'd0);
    chk("R10 stale id cleared busy", 32'(scaler_busy), 32'd1);
    chk("R10 stale id cleared mask", 32'(user_mask), 32'h20);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule